// File: doc/BRIEF.md
# ASID-Tagged Fully Associative Address Translator

This block turns a virtual address into a physical address in the same cycle that the lookup is presented. A small buffer of translation entries is searched in parallel. Every valid entry is compared against the virtual page number of the request and the address-space identifier that comes with it. Because the identifier is part of the tag, entries that belong to many processes can stay loaded together, and a context switch needs no flush. The three most significant address bits pick the segment type. Two kernel segments map straight to physical memory, one cached and one uncached. The user segment and the kernel virtual segment go through the buffer.

When a translated lookup finds no entry, the block raises a miss fault for a software refill handler. It does not walk page tables itself. The handler loads a complete entry at an index it chooses through a write port. A single control invalidates every entry at once. A lookup that hits marks its entry as referenced. A permitted store also marks the entry as dirty. A store to a read-only page, or an access from user mode to any kernel segment, raises a protection fault.

Top module: `tlb_xlate`

## Requirements
- R1: The low 12 bits of `lk_paddr` always equal the low 12 bits of `lk_vaddr`.
- R2: A translated lookup with `lk_valid`=1 hits only when some valid entry has a page number equal to `lk_vaddr[31:12]` and an identifier equal to `lk_asid`. On a hit, `lk_hit`=1 and `lk_paddr` = {entry frame, offset}. The same page number under a different identifier does not hit, so two processes can each keep an entry for the same page.
- R3: A translated lookup from a permitted mode that finds no matching entry gives `lk_miss`=1 and `lk_hit`=0, and `lk_paddr[31:12]`=0.
- R4: Segment decode uses `lk_vaddr[31:29]`. 0xx is the user segment and 11x is the kernel virtual segment, and both are translated. On a translated hit, `lk_cacheable` equals the cacheable bit of the entry.
- R5: For segment 100 and 101 in kernel mode (`lk_user`=0), `lk_paddr` = zero-extended `lk_vaddr[28:0]`, and neither `lk_hit` nor `lk_miss` is raised. `lk_cacheable` is 1 for 100 and 0 for 101.
- R6: `lk_prot_fault`=1 in two cases: a store (`lk_store`=1) that hits a read-only entry, or a user-mode access (`lk_user`=1) with `lk_vaddr[31]`=1. The store case leaves the dirty bit clear. The user case reports no hit and no miss, leaves the entry bits untouched, drives `lk_cacheable`=0, and leaves `lk_paddr[31:12]` zero in translated segments.
- R7: `lk_ent_ref`, `lk_ent_dirty` and `lk_ent_writable` show the matched entry as it was before the current lookup. A hit sets the referenced bit from the next cycle. A hit by a store to a writable entry also sets the dirty bit. With no hit, these three outputs are 0.
- R8: `wr_en`=1 loads every field at `wr_index`, and the new entry is visible from the next cycle. If a lookup hits the same index in that cycle, the write wins over its status update. An entry written with `wr_valid`=0 never hits.
- R9: `flush_all`=1 invalidates every entry from the next cycle. It wins over a write in the same cycle.
- R10: While `rst_n` is low, and after it rises, every entry is invalid, so translated lookups miss until the handler writes an entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| lk_valid | input | 1 | Lookup request present |
| lk_vaddr | input | 32 | Virtual address |
| lk_asid | input | 6 | Address-space identifier of the request |
| lk_store | input | 1 | Request is a store |
| lk_user | input | 1 | Request comes from user mode |
| wr_en | input | 1 | Load an entry |
| wr_index | input | IDX_W | Entry index to load |
| wr_vpn | input | 20 | Virtual page number of the new entry |
| wr_asid | input | 6 | Identifier of the new entry |
| wr_pfn | input | 20 | Physical frame number of the new entry |
| wr_valid | input | 1 | Valid bit of the new entry |
| wr_writable | input | 1 | 1 = read/write, 0 = read-only |
| wr_cacheable | input | 1 | Cacheable bit of the new entry |
| wr_dirty | input | 1 | Initial dirty bit |
| wr_ref | input | 1 | Initial referenced bit |
| flush_all | input | 1 | Invalidate all entries |
| lk_paddr | output | 32 | Physical address |
| lk_hit | output | 1 | Translated lookup hit |
| lk_miss | output | 1 | Miss fault for the refill handler |
| lk_prot_fault | output | 1 | Protection fault |
| lk_cacheable | output | 1 | Access may be cached |
| lk_ent_dirty | output | 1 | Dirty bit of the hit entry |
| lk_ent_ref | output | 1 | Referenced bit of the hit entry |
| lk_ent_writable | output | 1 | Access right of the hit entry |

## Verification
The bench builds the block with ENTRIES=8, so IDX_W is 3. The other parameters keep their defaults: 20-bit page numbers, 12-bit offsets and 6-bit identifiers. The smaller buffer lets a few refills reach both the lowest and the highest index. A flush can then be seen to clear entries across the whole array. Identifier aliasing, the boundary at the top of the user segment and the write-over-update collision at index 7 all stay within a short, directed run.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

  typedef enum logic [1:0] {
    SEG_USER,
    SEG_KPHYS_C,
    SEG_KPHYS_U,
    SEG_KVIRT
  } seg_e;

  // top three virtual address bits to segment type
  function automatic seg_e seg_of(input logic [2:0] top);
    seg_e s;
    if (!top[2])            s = SEG_USER;
    else if (top[1])        s = SEG_KVIRT;
    else if (top[0])        s = SEG_KPHYS_U;
    else                    s = SEG_KPHYS_C;
    return s;
  endfunction

endpackage

// File: rtl/tlb_seg_decode.sv
module tlb_seg_decode
  import tlb_pkg::*;
(
  input  logic [2:0] top_bits,
  output logic       translate,
  output logic       bypass,
  output logic       bypass_cach,
  output logic       kernel_seg
);

  seg_e kind;

  always_comb begin
    kind        = seg_of(top_bits);
    translate   = (kind == SEG_USER) || (kind == SEG_KVIRT);
    bypass      = (kind == SEG_KPHYS_C) || (kind == SEG_KPHYS_U);
    bypass_cach = (kind == SEG_KPHYS_C);
    kernel_seg  = (kind != SEG_USER);
  end

endmodule

// File: rtl/tlb_entry_array.sv
module tlb_entry_array #(
  parameter int ENTRIES = 64,
  parameter int VPN_W   = 20,
  parameter int ASID_W  = 6,
  parameter int PFN_W   = 20,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [VPN_W-1:0]  wr_vpn,
  input  logic [ASID_W-1:0] wr_asid,
  input  logic [PFN_W-1:0]  wr_pfn,
  input  logic              wr_valid,
  input  logic              wr_writable,
  input  logic              wr_cacheable,
  input  logic              wr_dirty,
  input  logic              wr_ref,
  input  logic [VPN_W-1:0]  key_vpn,
  input  logic [ASID_W-1:0] key_asid,
  input  logic              upd_en,
  input  logic              upd_store,
  output logic              found,
  output logic [PFN_W-1:0]  found_pfn,
  output logic              found_wrt,
  output logic              found_cch,
  output logic              found_dty,
  output logic              found_ref
);

  logic [ENTRIES-1:0]            match;
  logic [ENTRIES-1:0]            vld_all;
  logic [ENTRIES-1:0]            ref_all;
  logic [ENTRIES-1:0]            dty_all;
  logic [ENTRIES-1:0]            wrt_all;
  logic [ENTRIES-1:0]            cch_all;
  logic [ENTRIES-1:0][PFN_W-1:0] pfn_all;
  logic [IDX_W-1:0]              found_idx;

  for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
    logic              vld_q, vld_d, ref_q, ref_d, dty_q, dty_d;
    logic              wrt_q, cch_q;
    logic [VPN_W-1:0]  vpn_q;
    logic [ASID_W-1:0] asid_q;
    logic [PFN_W-1:0]  pfn_q;
    logic              ld, hit_me;

    assign ld     = wr_en && !flush && (wr_idx == IDX_W'(i));
    assign hit_me = upd_en && (found_idx == IDX_W'(i));

    // next state of the status bits: flush, then load, then hit update
    always_comb begin
      vld_d = vld_q;
      ref_d = ref_q;
      dty_d = dty_q;
      if (flush) begin
        vld_d = 1'b0;
      end else if (ld) begin
        vld_d = wr_valid;
        ref_d = wr_ref;
        dty_d = wr_dirty;
      end else if (hit_me) begin
        ref_d = 1'b1;
        if (upd_store && wrt_q) dty_d = 1'b1;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld_q <= 1'b0;
        ref_q <= 1'b0;
        dty_q <= 1'b0;
      end else begin
        vld_q <= vld_d;
        ref_q <= ref_d;
        dty_q <= dty_d;
      end
    end

    // tag and data fields: no reset, load enable only
    always_ff @(posedge clk) begin
      if (ld) begin
        vpn_q  <= wr_vpn;
        asid_q <= wr_asid;
        pfn_q  <= wr_pfn;
        wrt_q  <= wr_writable;
        cch_q  <= wr_cacheable;
      end
    end

    assign match[i]   = vld_q && (vpn_q == key_vpn) && (asid_q == key_asid);
    assign vld_all[i] = vld_q;
    assign ref_all[i] = ref_q;
    assign dty_all[i] = dty_q;
    assign wrt_all[i] = wrt_q;
    assign cch_all[i] = cch_q;
    assign pfn_all[i] = pfn_q;
  end

  // lowest matching index wins
  always_comb begin
    found     = 1'b0;
    found_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (match[i]) begin
        found     = 1'b1;
        found_idx = IDX_W'(i);
      end
    end
  end

  assign found_pfn = pfn_all[found_idx];
  assign found_wrt = wrt_all[found_idx];
  assign found_cch = cch_all[found_idx];
  assign found_dty = dty_all[found_idx];
  assign found_ref = ref_all[found_idx];

  // R9: a flush leaves no valid entry behind
  a_r9_flush_clears: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (vld_all == '0));

  // R7: a hit not overridden by a load marks its entry referenced
  a_r7_ref_after_hit: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en && !flush && !(wr_en && wr_idx == found_idx))
      |=> ref_all[$past(found_idx)]);

  // R8: a load takes the supplied valid bit
  a_r8_load_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !flush) |=> (vld_all[$past(wr_idx)] == $past(wr_valid)));

endmodule

// File: rtl/tlb_xlate.sv
module tlb_xlate #(
  parameter int ENTRIES = 64,
  parameter int VPN_W   = 20,
  parameter int OFF_W   = 12,
  parameter int ASID_W  = 6,
  parameter int PFN_W   = 20,
  localparam int VA_W   = VPN_W + OFF_W,
  localparam int PA_W   = PFN_W + OFF_W,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_valid,
  input  logic [VA_W-1:0]   lk_vaddr,
  input  logic [ASID_W-1:0] lk_asid,
  input  logic              lk_store,
  input  logic              lk_user,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_index,
  input  logic [VPN_W-1:0]  wr_vpn,
  input  logic [ASID_W-1:0] wr_asid,
  input  logic [PFN_W-1:0]  wr_pfn,
  input  logic              wr_valid,
  input  logic              wr_writable,
  input  logic              wr_cacheable,
  input  logic              wr_dirty,
  input  logic              wr_ref,
  input  logic              flush_all,
  output logic [PA_W-1:0]   lk_paddr,
  output logic              lk_hit,
  output logic              lk_miss,
  output logic              lk_prot_fault,
  output logic              lk_cacheable,
  output logic              lk_ent_dirty,
  output logic              lk_ent_ref,
  output logic              lk_ent_writable
);

  logic             translate, bypass, bypass_cach, kernel_seg;
  logic             user_fault, upd_en;
  logic             found, f_wrt, f_cch, f_dty, f_ref;
  logic [PFN_W-1:0] f_pfn;

  tlb_seg_decode u_seg (
    .top_bits    (lk_vaddr[VA_W-1 -: 3]),
    .translate   (translate),
    .bypass      (bypass),
    .bypass_cach (bypass_cach),
    .kernel_seg  (kernel_seg)
  );

  tlb_entry_array #(
    .ENTRIES (ENTRIES),
    .VPN_W   (VPN_W),
    .ASID_W  (ASID_W),
    .PFN_W   (PFN_W)
  ) u_array (
    .clk          (clk),
    .rst_n        (rst_n),
    .flush        (flush_all),
    .wr_en        (wr_en),
    .wr_idx       (wr_index),
    .wr_vpn       (wr_vpn),
    .wr_asid      (wr_asid),
    .wr_pfn       (wr_pfn),
    .wr_valid     (wr_valid),
    .wr_writable  (wr_writable),
    .wr_cacheable (wr_cacheable),
    .wr_dirty     (wr_dirty),
    .wr_ref       (wr_ref),
    .key_vpn      (lk_vaddr[VA_W-1 -: VPN_W]),
    .key_asid     (lk_asid),
    .upd_en       (upd_en),
    .upd_store    (lk_store),
    .found        (found),
    .found_pfn    (f_pfn),
    .found_wrt    (f_wrt),
    .found_cch    (f_cch),
    .found_dty    (f_dty),
    .found_ref    (f_ref)
  );

  always_comb begin
    user_fault      = lk_valid && lk_user && kernel_seg;
    upd_en          = lk_valid && translate && !user_fault && found;
    lk_hit          = upd_en;
    lk_miss         = lk_valid && translate && !user_fault && !found;
    lk_prot_fault   = user_fault || (upd_en && lk_store && !f_wrt);
    lk_ent_dirty    = upd_en && f_dty;
    lk_ent_ref      = upd_en && f_ref;
    lk_ent_writable = upd_en && f_wrt;
    if (bypass)
      lk_cacheable = lk_valid && !user_fault && bypass_cach;
    else
      lk_cacheable = upd_en && f_cch;
    if (bypass)
      lk_paddr = PA_W'(lk_vaddr[VA_W-4:0]);
    else if (upd_en)
      lk_paddr = {f_pfn, lk_vaddr[OFF_W-1:0]};
    else
      lk_paddr = {{PFN_W{1'b0}}, lk_vaddr[OFF_W-1:0]};
  end

  // R1: the page offset reaches the physical address untouched
  a_r1_offset: assert property (@(posedge clk) disable iff (!rst_n)
    lk_paddr[OFF_W-1:0] == lk_vaddr[OFF_W-1:0]);

  // R3: a miss excludes a hit and a protection fault
  a_r3_miss_alone: assert property (@(posedge clk) disable iff (!rst_n)
    lk_miss |-> (!lk_hit && !lk_prot_fault));

  // R5: kernel physical segments never report hit or miss
  a_r5_bypass_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && !lk_user && lk_vaddr[VA_W-1 -: 2] == 2'b10) |-> (!lk_hit && !lk_miss));

  // R6: a store hitting a read-only page faults
  a_r6_ro_store: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_hit && lk_store && !lk_ent_writable) |-> lk_prot_fault);

endmodule

// File: tb/tlb_xlate_bench.sv
`timescale 1ns/100ps
module tlb_xlate_bench;

  localparam int ENTRIES = 8;
  localparam int IDX_W   = 3;

  typedef struct packed {
    logic [31:0] pa;
    logic hit, miss, prot, cch, dty, rf, wrt;
  } exp_t;

  logic clk, rst_n;
  logic lk_valid, lk_store, lk_user;
  logic [31:0] lk_vaddr;
  logic [5:0]  lk_asid;
  logic wr_en, wr_valid, wr_writable, wr_cacheable, wr_dirty, wr_ref, flush_all;
  logic [IDX_W-1:0] wr_index;
  logic [19:0] wr_vpn, wr_pfn;
  logic [5:0]  wr_asid;
  logic [31:0] lk_paddr;
  logic lk_hit, lk_miss, lk_prot_fault, lk_cacheable;
  logic lk_ent_dirty, lk_ent_ref, lk_ent_writable;

  int errors = 0;
  int checks = 0;
  exp_t  exp_q[$];
  string tag_q[$];

  tlb_xlate #(.ENTRIES(ENTRIES)) u_tlb_xlate (
    .clk, .rst_n, .lk_valid, .lk_vaddr, .lk_asid, .lk_store, .lk_user,
    .wr_en, .wr_index, .wr_vpn, .wr_asid, .wr_pfn, .wr_valid, .wr_writable,
    .wr_cacheable, .wr_dirty, .wr_ref, .flush_all,
    .lk_paddr, .lk_hit, .lk_miss, .lk_prot_fault, .lk_cacheable,
    .lk_ent_dirty, .lk_ent_ref, .lk_ent_writable
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic exp_t mk(input logic [31:0] pa, input logic h, m, p, c, d, r, w);
    exp_t e;
    e = '{pa, h, m, p, c, d, r, w};
    return e;
  endfunction

  task automatic begin_cycle();
    @(posedge clk);
    #1;
    lk_valid = 0; lk_vaddr = '0; lk_asid = '0; lk_store = 0; lk_user = 0;
    wr_en = 0; flush_all = 0;
  endtask

  task automatic set_lookup(input logic [31:0] va, input logic [5:0] asid,
                            input logic st, input logic usr, input exp_t e,
                            input string tag);
    lk_valid = 1; lk_vaddr = va; lk_asid = asid; lk_store = st; lk_user = usr;
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  task automatic set_write(input logic [IDX_W-1:0] idx, input logic [19:0] vpn,
                           input logic [5:0] asid, input logic [19:0] pfn,
                           input logic v, w, c, d, r);
    wr_en = 1; wr_index = idx; wr_vpn = vpn; wr_asid = asid; wr_pfn = pfn;
    wr_valid = v; wr_writable = w; wr_cacheable = c; wr_dirty = d; wr_ref = r;
  endtask

  // monitor: compare one expected item per cycle, away from the clock edge
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      exp_t e, a;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      a = '{lk_paddr, lk_hit, lk_miss, lk_prot_fault, lk_cacheable,
            lk_ent_dirty, lk_ent_ref, lk_ent_writable};
      checks++;
      if (a !== e) begin
        errors++;
        $display("FAIL %s actual=%h expected=%h", t, a, e);
      end
    end
  end

  initial begin
    #(5.0 * 20000);
    errors++;
    $display("FAIL watchdog R1 actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 0;
    lk_valid = 0; lk_vaddr = '0; lk_asid = '0; lk_store = 0; lk_user = 0;
    wr_en = 0; wr_index = '0; wr_vpn = '0; wr_asid = '0; wr_pfn = '0;
    wr_valid = 0; wr_writable = 0; wr_cacheable = 0; wr_dirty = 0; wr_ref = 0;
    flush_all = 0;
    begin_cycle();
    set_lookup(32'h00012ABC, 6'd1, 0, 1, mk(32'h00000ABC,0,1,0,0,0,0,0), "R10 miss in reset");
    begin_cycle();
    rst_n = 1;
    set_lookup(32'h00012ABC, 6'd1, 0, 1, mk(32'h00000ABC,0,1,0,0,0,0,0), "R10 miss after reset");

    begin_cycle(); set_write(0, 20'h00012, 6'd1, 20'hABCDE, 1, 0, 1, 0, 0);
    begin_cycle(); set_write(7, 20'h00012, 6'd2, 20'h11111, 1, 1, 0, 0, 0);
    begin_cycle(); set_lookup(32'h00012ABC, 6'd1, 0, 1, mk(32'hABCDEABC,1,0,0,1,0,0,0), "R2 hit asid1");
    begin_cycle(); set_lookup(32'h00012ABC, 6'd1, 0, 1, mk(32'hABCDEABC,1,0,0,1,0,1,0), "R7 ref set");
    begin_cycle(); set_lookup(32'h00012ABC, 6'd2, 1, 1, mk(32'h11111ABC,1,0,0,0,0,0,1), "R4 asid2 entry cacheability");
    begin_cycle(); set_lookup(32'h00012ABC, 6'd2, 0, 1, mk(32'h11111ABC,1,0,0,0,1,1,1), "R7 dirty set");
    begin_cycle(); set_lookup(32'h00012ABC, 6'd3, 0, 1, mk(32'h00000ABC,0,1,0,0,0,0,0), "R3 foreign asid miss");
    begin_cycle(); set_lookup(32'h00012ABC, 6'd1, 1, 1, mk(32'hABCDEABC,1,0,1,1,0,1,0), "R6 read-only store");
    begin_cycle(); set_lookup(32'h00012ABC, 6'd1, 0, 1, mk(32'hABCDEABC,1,0,0,1,0,1,0), "R6 dirty stays clear");
    begin_cycle(); set_lookup(32'h81234567, 6'd9, 0, 0, mk(32'h01234567,0,0,0,1,0,0,0), "R5 cached bypass");
    begin_cycle(); set_lookup(32'hA1234567, 6'd9, 1, 0, mk(32'h01234567,0,0,0,0,0,0,0), "R5 uncached bypass");
    begin_cycle(); set_lookup(32'h81234567, 6'd9, 0, 1, mk(32'h01234567,0,0,1,0,0,0,0), "R6 user in kernel phys");

    begin_cycle(); set_write(3, 20'hE0001, 6'd5, 20'h00333, 1, 1, 1, 0, 0);
    begin_cycle(); set_lookup(32'hE0001010, 6'd5, 0, 1, mk(32'h00000010,0,0,1,0,0,0,0), "R6 user in kernel virt");
    begin_cycle(); set_lookup(32'hE0001010, 6'd5, 0, 0, mk(32'h00333010,1,0,0,1,0,0,1), "R4 kernel virt hit, ref untouched");
    begin_cycle(); set_lookup(32'hE0001010, 6'd5, 0, 0, mk(32'h00333010,1,0,0,1,0,1,1), "R7 kernel virt ref");

    begin_cycle(); set_write(5, 20'h7FFFF, 6'd0, 20'hFFFFF, 1, 0, 0, 0, 0);
    begin_cycle(); set_lookup(32'h7FFFFFFF, 6'd0, 0, 1, mk(32'hFFFFFFFF,1,0,0,0,0,0,0), "R4 top of user segment");
    begin_cycle(); set_lookup(32'h7FFFFFFF, 6'd1, 0, 1, mk(32'h00000FFF,0,1,0,0,0,0,0), "R2 asid must match");

    begin_cycle(); set_write(2, 20'h00055, 6'd1, 20'h55555, 0, 1, 1, 0, 0);
    begin_cycle(); set_lookup(32'h00055000, 6'd1, 0, 1, mk(32'h00000000,0,1,0,0,0,0,0), "R8 invalid write no hit");

    begin_cycle();
    set_lookup(32'h00012ABC, 6'd2, 1, 1, mk(32'h11111ABC,1,0,0,0,1,1,1), "R8 old entry this cycle");
    set_write(7, 20'h00099, 6'd2, 20'h22222, 1, 1, 1, 0, 0);
    begin_cycle(); set_lookup(32'h00099000, 6'd2, 0, 1, mk(32'h22222000,1,0,0,1,0,0,1), "R8 write beats update");
    begin_cycle(); set_lookup(32'h00012ABC, 6'd2, 0, 1, mk(32'h00000ABC,0,1,0,0,0,0,0), "R8 old tag gone");

    begin_cycle();
    flush_all = 1;
    set_write(1, 20'h00044, 6'd1, 20'h44444, 1, 1, 1, 0, 0);
    begin_cycle(); set_lookup(32'h00044000, 6'd1, 0, 1, mk(32'h00000000,0,1,0,0,0,0,0), "R9 flush beats write");
    begin_cycle(); set_lookup(32'h00012ABC, 6'd1, 0, 1, mk(32'h00000ABC,0,1,0,0,0,0,0), "R9 index0 flushed");
    begin_cycle(); set_lookup(32'hE0001010, 6'd5, 0, 0, mk(32'h00000010,0,1,0,0,0,0,0), "R9 index3 flushed");
    begin_cycle(); set_lookup(32'h00099000, 6'd2, 0, 1, mk(32'h00000000,0,1,0,0,0,0,0), "R9 index7 flushed");

    begin_cycle(); set_write(1, 20'h00044, 6'd1, 20'h44444, 1, 1, 1, 0, 0);
    begin_cycle(); set_lookup(32'h00044123, 6'd1, 0, 1, mk(32'h44444123,1,0,0,1,0,0,1), "R8 refill after flush R1");

    begin_cycle();
    repeat (3) @(posedge clk);
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R1 queue actual=%0d expected=0", exp_q.size());
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule